// File: doc/BRIEF.md
# Serial DAC Write Controller

This block sits on the host side of a serial digital-to-analog converter link. It takes a 16-bit word through a ready/valid handshake and sends it as one frame on a three-wire link: a serial clock, an active-low frame select and a data line. A separate active-low load strobe tells the converter when to update its output. Every minimum time the link needs is a parameter given in system clock cycles, so the caller rounds each nanosecond limit up to whole cycles once, when the block is instantiated.

The word goes out most significant bit first. Each data bit is presented for a full high phase of the serial clock. It is captured on the falling edge and held through the low phase that follows. The serial clock idles high and toggles only while the frame select is low. A mode input, sampled when the word is accepted, picks the load behaviour. In pulse mode a separate low pulse follows the frame. In held mode the strobe falls on the first falling clock edge and stays low until the frame select rises. A guard interval with frame select high always ends the transaction.

The state machine has six states: IDLE, LEAD, LOW, HIGH, PULSE and GAP. Its transitions are:
- IDLE to LEAD on an accepted word.
- LEAD to LOW after the lead time.
- LOW to HIGH after a half period, when bits remain.
- HIGH to LOW after a half period.
- LOW to PULSE after the last bit, in pulse mode.
- LOW to GAP after the last bit, in held mode.
- PULSE to GAP after the pulse width.
- GAP to IDLE after the idle time.

Top module: `dac_wr_ctrl`

## Requirements
- R1: A synchronous active-high reset, applied at any time, returns the block to idle. In the cycle after the reset edge, sync_n, load_n and sclk are 1, busy is 0 and in_ready is 1.
- R2: A word is taken on a clock edge where in_valid and in_ready are both 1. From the next cycle busy is 1 and in_ready is 0 until the transaction ends.
- R3: Each frame has exactly 16 sclk falling edges while sync_n is low. The bits seen on din at those edges, in order, equal in_word[15] down to in_word[0].
- R4: din changes only on a rising sclk edge or when the frame starts. It is unchanged on the cycle sclk falls and throughout each low phase.
- R5: Inside a frame, every sclk low phase lasts DIV_HALF cycles, and so does every high phase after the first fall. Outside a frame, sclk stays 1.
- R6: sync_n falls exactly LEAD_MIN cycles before the first sclk falling edge, with sclk high in between.
- R7: sync_n rises exactly DIV_HALF cycles after the 16th falling edge, while sclk is still low, and sclk returns high in that same cycle.
- R8: Between two frames sync_n stays high for at least IDLE_MIN cycles. With in_valid held, the high time is (pulse mode ? PULSE_MIN : 0) + IDLE_MIN + 1 cycles.
- R9: With in_sync_mode = 0 (pulse mode), load_n falls in the cycle sync_n rises and stays low for exactly PULSE_MIN cycles.
- R10: With in_sync_mode = 1 (held mode), load_n falls in the cycle of the first sclk falling edge and rises in the cycle sync_n rises.
- R11: in_sync_mode is sampled only when a word is accepted. Changing it during a transaction has no effect on that transaction's load_n.
- R12: busy is 1 whenever sync_n or load_n is low. It falls exactly IDLE_MIN cycles after the end of the load pulse in pulse mode, or after the sync_n rise in held mode.
- R13: in_valid asserted while busy is 1 is ignored. No further frame starts after the transaction ends unless in_valid is asserted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word offered |
| in_word | input | 16 | Word to send, bit 15 first |
| in_sync_mode | input | 1 | Load behaviour: 0 pulse after frame, 1 held low through frame |
| in_ready | output | 1 | Block can take a word |
| busy | output | 1 | Transaction in progress |
| sclk | output | 1 | Serial clock, idles high |
| sync_n | output | 1 | Active-low frame select |
| din | output | 1 | Serial data |
| load_n | output | 1 | Active-low converter load strobe |

## Verification
The hardest case to reach from the ports is a mode change during a transaction, and right behind it a second word that is already waiting when the guard interval ends. Both need the input side to change while the block is busy, at a chosen point in the frame. The stimulus flips in_sync_mode one cycle after acceptance. It also holds in_valid high across two transactions, so the second frame starts on the first idle cycle and the frame-select high time is measured at its minimum. A stray in_valid burst in the middle of a frame, and a reset that lands part way through a frame, cover the ignore and abort paths.

// File: rtl/dac_wr_pkg.sv
`timescale 1ns/1ps
package dac_wr_pkg;
    localparam int FRAME_BITS = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_PULSE,
        ST_GAP
    } wr_state_e;
endpackage

// File: rtl/dac_wr_timer.sv
`timescale 1ns/1ps
module dac_wr_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/dac_wr_shift.sv
`timescale 1ns/1ps
module dac_wr_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         msb,
    output logic         last
);
    localparam int NW = $clog2(W + 1);

    logic [W-1:0]  sr;
    logic [NW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            left <= '0;
        end else if (load) begin
            sr   <= load_word;
            left <= NW'(W);
        end else if (shift) begin
            sr   <= {sr[W-2:0], 1'b0};
            left <= left - 1'b1;
        end
    end

    assign msb  = sr[W-1];
    assign last = (left == NW'(1));
endmodule

// File: rtl/dac_wr_ctrl.sv
`timescale 1ns/1ps
module dac_wr_ctrl
    import dac_wr_pkg::*;
#(
    parameter int DIV_HALF  = 4,
    parameter int LEAD_MIN  = 3,
    parameter int PULSE_MIN = 4,
    parameter int IDLE_MIN  = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] in_word,
    input  logic        in_sync_mode,
    output logic        in_ready,
    output logic        busy,
    output logic        sclk,
    output logic        sync_n,
    output logic        din,
    output logic        load_n
);
    localparam int H_C  = (DIV_HALF  < 1) ? 1 : DIV_HALF;
    localparam int L_C  = (LEAD_MIN  < 1) ? 1 : LEAD_MIN;
    localparam int P_C  = (PULSE_MIN < 1) ? 1 : PULSE_MIN;
    localparam int I_C  = (IDLE_MIN  < 1) ? 1 : IDLE_MIN;
    localparam int M1   = (H_C > L_C) ? H_C : L_C;
    localparam int M2   = (P_C > I_C) ? P_C : I_C;
    localparam int MAXC = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] H_LD = CW'(H_C - 1);
    localparam logic [CW-1:0] L_LD = CW'(L_C - 1);
    localparam logic [CW-1:0] P_LD = CW'(P_C - 1);
    localparam logic [CW-1:0] I_LD = CW'(I_C - 1);

    wr_state_e     state, nxt;
    logic          mode_q;
    logic          tmr_load, tmr_done;
    logic [CW-1:0] tmr_val;
    logic          sh_load, sh_shift, sh_msb, sh_last;

    dac_wr_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    dac_wr_shift #(.W(FRAME_BITS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .load_word (in_word),
        .shift     (sh_shift),
        .msb       (sh_msb),
        .last      (sh_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Load mode captured with the word
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
        end else if (sh_load) begin
            mode_q <= in_sync_mode;
        end
    end

    // Transitions and datapath controls
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) begin
                    nxt      = ST_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = L_LD;
                    sh_load  = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tmr_done) begin
                    nxt      = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = H_LD;
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (!sh_last) begin
                        nxt      = ST_HIGH;
                        tmr_val  = H_LD;
                        sh_shift = 1'b1;
                    end else if (mode_q) begin
                        nxt     = ST_GAP;
                        tmr_val = I_LD;
                    end else begin
                        nxt     = ST_PULSE;
                        tmr_val = P_LD;
                    end
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    nxt      = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = H_LD;
                end
            end
            ST_PULSE: begin
                if (tmr_done) begin
                    nxt      = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = I_LD;
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        sync_n = 1'b1;
        sclk   = 1'b1;
        load_n = 1'b1;
        din    = 1'b0;
        busy   = 1'b1;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_LEAD: begin
                sync_n = 1'b0;
                din    = sh_msb;
            end
            ST_LOW: begin
                sync_n = 1'b0;
                sclk   = 1'b0;
                din    = sh_msb;
                load_n = !mode_q;
            end
            ST_HIGH: begin
                sync_n = 1'b0;
                din    = sh_msb;
                load_n = !mode_q;
            end
            ST_PULSE: load_n = 1'b0;
            ST_GAP:   busy   = 1'b1;
            default:  busy   = 1'b1;
        endcase
    end

    assign in_ready = (state == ST_IDLE);
endmodule

// File: rtl/dac_wr_ctrl_chk.sv
`timescale 1ns/1ps
module dac_wr_ctrl_chk #(
    parameter int LEAD_MIN  = 3,
    parameter int PULSE_MIN = 4,
    parameter int IDLE_MIN  = 10
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic sclk,
    input logic sync_n,
    input logic din,
    input logic load_n
);
    logic        sclk_q, syncn_q, framed;
    logic [4:0]  fall_cnt;
    logic [15:0] lead_cnt, hi_cnt, lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b1;
            syncn_q  <= 1'b1;
            framed   <= 1'b0;
            fall_cnt <= '0;
            lead_cnt <= '0;
            hi_cnt   <= '0;
            lo_cnt   <= '0;
        end else begin
            sclk_q  <= sclk;
            syncn_q <= sync_n;
            if (!syncn_q && sync_n) framed <= 1'b1;
            if (syncn_q && !sync_n) fall_cnt <= '0;
            else if (sclk_q && !sclk && fall_cnt != 5'd31) fall_cnt <= fall_cnt + 1'b1;
            if (sync_n || !sclk) lead_cnt <= '0;
            else if (lead_cnt != 16'hFFFF) lead_cnt <= lead_cnt + 1'b1;
            if (!sync_n) hi_cnt <= '0;
            else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
            if (load_n) lo_cnt <= '0;
            else if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (sync_n && load_n && sclk && !busy)); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && !in_ready)); // R2
    AST_SIXTEEN_FALLS: assert property (@(posedge clk) disable iff (rst)
        ($rose(sync_n) && !$past(rst)) |-> (fall_cnt == 5'd16)); // R3
    AST_DIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sclk && !$past(sclk) && !sync_n) |-> $stable(din)); // R4
    AST_DIN_SETUP: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk) && !$past(rst)) |-> $stable(din)); // R4
    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        !sclk |-> !sync_n); // R5
    AST_LEAD_TIME: assert property (@(posedge clk) disable iff (rst)
        ($fell(sclk) && fall_cnt == 5'd0 && !$past(rst)) |-> (lead_cnt >= 16'(LEAD_MIN))); // R6
    AST_RISE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        ($rose(sync_n) && !$past(rst)) |-> !$past(sclk)); // R7
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($fell(sync_n) && framed) |-> (hi_cnt >= 16'(IDLE_MIN))); // R8
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ($rose(load_n) && !$past(rst)) |-> (lo_cnt >= 16'(PULSE_MIN))); // R9
    AST_LOAD_FALL_EDGE: assert property (@(posedge clk) disable iff (rst)
        ($fell(load_n) && !$past(rst)) |-> (sync_n || $fell(sclk))); // R10
    AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (rst)
        (!sync_n || !load_n) |-> busy); // R12
endmodule

bind dac_wr_ctrl dac_wr_ctrl_chk #(
    .LEAD_MIN  (LEAD_MIN),
    .PULSE_MIN (PULSE_MIN),
    .IDLE_MIN  (IDLE_MIN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .busy     (busy),
    .sclk     (sclk),
    .sync_n   (sync_n),
    .din      (din),
    .load_n   (load_n)
);

// File: tb/dac_wr_ctrl_test.sv
`timescale 1ns/1ps
module dac_wr_ctrl_test;
    localparam int H  = 4;
    localparam int L  = 3;
    localparam int P  = 5;
    localparam int I  = 10;
    localparam int SYNC_LOW = 31 * H;
    localparam int NV = 5;
    // {mode, word, expected load_n low length}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 16'hA5C3, 8'(P)},
        {1'b1, 16'h0000, 8'(SYNC_LOW)},
        {1'b0, 16'hFFFF, 8'(P)},
        {1'b1, 16'h8001, 8'(SYNC_LOW)},
        {1'b0, 16'h1234, 8'(P)}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_sync_mode = 1'b0;
    logic        in_ready, busy, sclk, sync_n, din, load_n;

    int checks = 0;
    int failures = 0;

    dac_wr_ctrl #(.DIV_HALF(H), .LEAD_MIN(L), .PULSE_MIN(P), .IDLE_MIN(I)) uut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_word      (in_word),
        .in_sync_mode (in_sync_mode),
        .in_ready     (in_ready),
        .busy         (busy),
        .sclk         (sclk),
        .sync_n       (sync_n),
        .din          (din),
        .load_n       (load_n)
    );

    always #2.5 clk = ~clk;

    // Port monitor, sampled on the falling clock edge
    int cyc = 0, frames = 0, falls = 0, run = 0, ph_bad = 0, d_bad = 0;
    int t_sfall = 0, t_srise = 0, t_first = 0, t_last = 0, t_lfall = 0, t_lrise = 0, t_bfall = 0;
    logic [15:0] cap = '0;
    logic p_sclk = 1'b1, p_sync = 1'b1, p_load = 1'b1, p_busy = 1'b0, p_din = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (p_sync && !sync_n) begin
            frames++; t_sfall = cyc; falls = 0; cap = '0; ph_bad = 0; d_bad = 0;
        end
        if (!p_sync && sync_n) t_srise = cyc;
        if (!sync_n && p_sclk && !sclk) begin
            falls++;
            cap = {cap[14:0], din};
            if (falls == 1) t_first = cyc;
            t_last = cyc;
            if (din != p_din) d_bad++;
        end
        if (!sync_n && !p_sclk && !sclk && din != p_din) d_bad++;
        if (sclk != p_sclk) begin
            if (!sync_n && !p_sync && (!p_sclk || falls > 1) && run != H) ph_bad++;
            run = 1;
        end else begin
            run++;
        end
        if (p_load && !load_n) t_lfall = cyc;
        if (!p_load && load_n) t_lrise = cyc;
        if (p_busy && !busy) t_bfall = cyc;
        p_sclk = sclk; p_sync = sync_n; p_load = load_n; p_busy = busy; p_din = din;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_done();
        while (busy) tick();
        tick();
    endtask

    task automatic run_frame(input logic [15:0] w, input logic m);
        while (!in_ready) tick();
        in_valid = 1'b1; in_word = w; in_sync_mode = m;
        tick();
        in_valid = 1'b0;
        chk("R2 busy after accept", int'(busy), 1);
        chk("R2 ready low while busy", int'(in_ready), 0);
        wait_done();
    endtask

    task automatic check_frame(input logic [15:0] w, input logic m, input int llen);
        chk("R3 captured word", int'(cap), int'(w));
        chk("R3 falling edges", falls, 16);
        chk("R4 data stability", d_bad, 0);
        chk("R5 phase lengths", ph_bad, 0);
        chk("R6 lead time", t_first - t_sfall, L);
        chk("R7 select rise after last fall", t_srise - t_last, H);
        chk(m ? "R10 load low length" : "R9 load low length", t_lrise - t_lfall, llen);
        if (m) begin
            chk("R10 load falls on first fall", t_lfall - t_first, 0);
            chk("R10 load rises with select", t_lrise - t_srise, 0);
        end else begin
            chk("R9 load falls with select", t_lfall - t_srise, 0);
        end
        chk("R12 busy end", t_bfall - t_srise, (m ? 0 : P) + I);
        chk("R5 sclk idle high", int'(sclk), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int f0, r1;
        repeat (3) tick();
        // R1 reset state
        chk("R1 sync_n in reset", int'(sync_n), 1);
        chk("R1 load_n in reset", int'(load_n), 1);
        chk("R1 sclk in reset", int'(sclk), 1);
        chk("R1 busy in reset", int'(busy), 0);
        rst = 1'b0;
        tick();
        chk("R1 ready after reset", int'(in_ready), 1);

        // Table of frames
        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i][23:8], VEC[i][24]);
            check_frame(VEC[i][23:8], VEC[i][24], int'(VEC[i][7:0]));
        end

        // R11 mode changed mid-transaction
        while (!in_ready) tick();
        in_valid = 1'b1; in_word = 16'h5A5A; in_sync_mode = 1'b0;
        tick();
        in_valid = 1'b0; in_sync_mode = 1'b1;
        wait_done();
        chk("R11 load pulse kept after mode flip", t_lfall - t_srise, 0);
        chk("R11 pulse length after mode flip", t_lrise - t_lfall, P);
        in_sync_mode = 1'b0;

        // R13 valid during busy ignored
        f0 = frames;
        in_valid = 1'b1; in_word = 16'hC001;
        tick();
        in_valid = 1'b0;
        repeat (20) tick();
        in_valid = 1'b1; in_word = 16'h7777;
        repeat (3) tick();
        in_valid = 1'b0;
        wait_done();
        repeat (20) tick();
        chk("R13 no extra frame", frames - f0, 1);
        chk("R13 word kept", int'(cap), 16'hC001);
        chk("R13 idle after", int'(busy), 0);

        // R8 back-to-back frames, pulse mode
        f0 = frames;
        in_valid = 1'b1; in_word = 16'h0F0F; in_sync_mode = 1'b0;
        while (frames == f0) tick();
        while (!sync_n || !busy) tick();
        tick();
        r1 = t_srise;
        while (frames < f0 + 2) tick();
        in_valid = 1'b0;
        chk("R8 select high between frames", t_sfall - r1, P + I + 1);
        wait_done();
        chk("R3 second back-to-back word", int'(cap), 16'h0F0F);

        // R1 reset in the middle of a frame
        in_valid = 1'b1; in_word = 16'hFFFF; in_sync_mode = 1'b1;
        tick();
        in_valid = 1'b0;
        repeat (40) tick();
        rst = 1'b1;
        tick();
        chk("R1 mid-frame reset sync_n", int'(sync_n), 1);
        chk("R1 mid-frame reset load_n", int'(load_n), 1);
        chk("R1 mid-frame reset sclk", int'(sclk), 1);
        chk("R1 mid-frame reset busy", int'(busy), 0);
        rst = 1'b0;
        tick();
        chk("R1 ready after mid-frame reset", int'(in_ready), 1);

        // Frame after abort is complete
        run_frame(16'h3C96, 1'b0);
        check_frame(16'h3C96, 1'b0, P);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule